// File: doc/BRIEF.md
# Nibble Accumulator Execute Unit

This block is the arithmetic execute stage of a small 4-bit controller. It holds a 4-bit accumulator and a 1-bit carry flag. On each cycle where the instruction strobe is high it decodes one 8-bit opcode and updates the accumulator and carry. The operand for the operations that read memory is a 4-bit RAM word supplied on its own input.

Several additions use skip-on-carry semantics. When their carry out is 1, the block raises a one-cycle skip request. The instruction sequencer uses that request to discard the following instruction. Opcodes outside the supported set change no state and raise a one-cycle illegal flag instead. Instruction fetch, program counting, RAM addressing and I/O are handled by neighbouring blocks.

Top module: `nib_exec`

## Requirements
- R1: When the synchronous reset `rst` is sampled high at a clock edge, the accumulator, the carry, `skip_o` and `illegal_o` are all 0 after that edge.
- R2: Opcode 0x30 computes the 5-bit sum accumulator + carry + RAM word. Its low 4 bits go to the accumulator and bit 4 goes to the carry. `skip_o` is 1 in the next cycle exactly when bit 4 is 1.
- R3: Opcode 0x31 writes (accumulator + RAM word) mod 16 to the accumulator. The carry is left unchanged and no skip is requested, even when the sum overflows.
- R4: Opcodes 0x51 to 0x5F add the low opcode nibble (1 to 15) to the accumulator, mod 16. A skip is requested when the sum exceeds 15. The carry is never changed.
- R5: Opcode 0x00 clears the accumulator. Opcode 0x40 replaces the accumulator with its bitwise inverse. Neither changes the carry or requests a skip.
- R6: Opcode 0x32 clears the carry and opcode 0x22 sets it. The accumulator is unchanged.
- R7: Opcode 0x02 replaces the accumulator with accumulator XOR RAM word. Opcode 0x44 changes no state and raises no flag.
- R8: Opcode 0x50 and every opcode not named in R2 to R7 leave the accumulator and carry unchanged. They raise `illegal_o` for one cycle and do not request a skip.
- R9: `skip_o` and `illegal_o` are registered pulses. They are high only in the cycle right after a strobe that calls for them, and they are never high together. A cycle without a strobe changes neither the accumulator nor the carry, and it leaves both flags low in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| instr_valid | input | 1 | Instruction strobe; executes `opcode` this cycle |
| opcode | input | 8 | Instruction byte |
| ram_nib | input | 4 | RAM operand word |
| acc_o | output | 4 | Accumulator |
| carry_o | output | 1 | Carry flag |
| skip_o | output | 1 | Skip-next-instruction request, one cycle |
| illegal_o | output | 1 | Unsupported opcode seen, one cycle |

## Verification
The additions are each driven with operand pairs whose sum lands just under 16 and just over it. For the carry-in add, the pairs are run with the carry both clear and set. This shows whether the carry feeds the sum, reaches the carry flag, or only drives the skip request. The immediate add is run at its smallest and largest immediate values, starting from a set carry, to show that the carry is left alone on overflow. The invalid-immediate opcode and a scattering of unlisted opcodes are issued between known accumulator values to show that they hold state. Idle cycles placed after a skipping instruction show that the flags are single-cycle pulses.

// File: rtl/nib_exec_pkg.sv
package nib_exec_pkg;

    localparam int NIB_W = 4;
    localparam int OPC_W = 8;

    typedef enum logic [3:0] {
        K_ADDC,
        K_ADD,
        K_ADDI,
        K_CLR,
        K_INV,
        K_NOP,
        K_CCLR,
        K_CSET,
        K_XOR,
        K_BAD
    } op_kind_e;

    typedef struct packed {
        op_kind_e         kind;
        logic [NIB_W-1:0] imm;
    } dec_t;

    typedef struct packed {
        logic [NIB_W-1:0] acc;
        logic             carry;
        logic             skip;
        logic             bad;
    } exec_t;

    function automatic dec_t decode_op(logic [OPC_W-1:0] op);
        dec_t d;
        d.imm  = op[NIB_W-1:0];
        d.kind = K_BAD;
        unique case (op)
            8'h30:   d.kind = K_ADDC;
            8'h31:   d.kind = K_ADD;
            8'h00:   d.kind = K_CLR;
            8'h40:   d.kind = K_INV;
            8'h44:   d.kind = K_NOP;
            8'h32:   d.kind = K_CCLR;
            8'h22:   d.kind = K_CSET;
            8'h02:   d.kind = K_XOR;
            default: begin
                if (op[7:4] == 4'h5 && op[3:0] != 4'h0)
                    d.kind = K_ADDI;
                else
                    d.kind = K_BAD;
            end
        endcase
        return d;
    endfunction

endpackage

// File: rtl/nib_exec_decode.sv
module nib_exec_decode
    import nib_exec_pkg::*;
(
    input  logic [OPC_W-1:0] opcode,
    output dec_t             dec
);
    always_comb dec = decode_op(opcode);
endmodule

// File: rtl/nib_exec_adder.sv
module nib_exec_adder #(
    parameter int W      = 4,
    parameter bit RIPPLE = 1'b1
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         cin,
    output logic [W-1:0] sum,
    output logic         cout
);
    generate
        if (RIPPLE) begin : g_ripple
            logic [W:0] c;
            assign c[0] = cin;
            for (genvar i = 0; i < W; i++) begin : g_bit
                assign sum[i]  = a[i] ^ b[i] ^ c[i];
                assign c[i+1]  = (a[i] & b[i]) | (c[i] & (a[i] ^ b[i]));
            end
            assign cout = c[W];
        end else begin : g_flat
            logic [W:0] s;
            assign s    = {1'b0, a} + {1'b0, b} + {{W{1'b0}}, cin};
            assign sum  = s[W-1:0];
            assign cout = s[W];
        end
    endgenerate
endmodule

// File: rtl/nib_exec_alu.sv
module nib_exec_alu
    import nib_exec_pkg::*;
#(
    parameter int W      = NIB_W,
    parameter bit RIPPLE = 1'b1
) (
    input  dec_t         dec,
    input  logic [W-1:0] acc,
    input  logic         carry,
    input  logic [W-1:0] ram_nib,
    output exec_t        nxt
);
    logic [W-1:0] add_b;
    logic         add_cin;
    logic [W-1:0] add_sum;
    logic         add_cout;

    assign add_b   = (dec.kind == K_ADDI) ? dec.imm : ram_nib;
    assign add_cin = (dec.kind == K_ADDC) ? carry : 1'b0;

    nib_exec_adder #(.W(W), .RIPPLE(RIPPLE)) u_add (
        .a    (acc),
        .b    (add_b),
        .cin  (add_cin),
        .sum  (add_sum),
        .cout (add_cout)
    );

    always_comb begin
        nxt.acc   = acc;
        nxt.carry = carry;
        nxt.skip  = 1'b0;
        nxt.bad   = 1'b0;
        unique case (dec.kind)
            K_ADDC: begin
                nxt.acc   = add_sum;
                nxt.carry = add_cout;
                nxt.skip  = add_cout;
            end
            K_ADD:  nxt.acc = add_sum;
            K_ADDI: begin
                nxt.acc  = add_sum;
                nxt.skip = add_cout;
            end
            K_CLR:  nxt.acc   = '0;
            K_INV:  nxt.acc   = ~acc;
            K_CCLR: nxt.carry = 1'b0;
            K_CSET: nxt.carry = 1'b1;
            K_XOR:  nxt.acc   = acc ^ ram_nib;
            K_NOP:  ;
            default: nxt.bad  = 1'b1;
        endcase
    end
endmodule

// File: rtl/nib_exec_regs.sv
module nib_exec_regs
    import nib_exec_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  load,
    input  exec_t nxt,
    output exec_t cur
);
    always_ff @(posedge clk) begin
        if (rst) begin
            cur <= '0;
        end else if (load) begin
            cur <= nxt;
        end else begin
            cur.skip <= 1'b0;
            cur.bad  <= 1'b0;
        end
    end
endmodule

// File: rtl/nib_exec.sv
module nib_exec
    import nib_exec_pkg::*;
#(
    parameter bit RIPPLE = 1'b1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             instr_valid,
    input  logic [OPC_W-1:0] opcode,
    input  logic [NIB_W-1:0] ram_nib,
    output logic [NIB_W-1:0] acc_o,
    output logic             carry_o,
    output logic             skip_o,
    output logic             illegal_o
);
    dec_t  dec;
    exec_t nxt;
    exec_t cur;

    nib_exec_decode u_dec (
        .opcode (opcode),
        .dec    (dec)
    );

    nib_exec_alu #(.W(NIB_W), .RIPPLE(RIPPLE)) u_alu (
        .dec     (dec),
        .acc     (cur.acc),
        .carry   (cur.carry),
        .ram_nib (ram_nib),
        .nxt     (nxt)
    );

    nib_exec_regs u_regs (
        .clk  (clk),
        .rst  (rst),
        .load (instr_valid),
        .nxt  (nxt),
        .cur  (cur)
    );

    assign acc_o     = cur.acc;
    assign carry_o   = cur.carry;
    assign skip_o    = cur.skip;
    assign illegal_o = cur.bad;
endmodule

// File: rtl/nib_exec_chk.sv
module nib_exec_chk (
    input logic       clk,
    input logic       rst,
    input logic       instr_valid,
    input logic [7:0] opcode,
    input logic [3:0] acc_o,
    input logic       carry_o,
    input logic       skip_o,
    input logic       illegal_o
);
    p_reset_r1: assert property (@(posedge clk)
        rst |=> (acc_o == 4'h0) && !carry_o && !skip_o && !illegal_o);

    p_addc_skip_r2: assert property (@(posedge clk) disable iff (rst)
        (instr_valid && opcode == 8'h30) |=> (skip_o == carry_o) && !illegal_o);

    p_add_keep_r3: assert property (@(posedge clk) disable iff (rst)
        (instr_valid && opcode == 8'h31) |=> $stable(carry_o) && !skip_o);

    p_imm_keep_r4: assert property (@(posedge clk) disable iff (rst)
        (instr_valid && opcode[7:4] == 4'h5 && opcode[3:0] != 4'h0)
        |=> $stable(carry_o) && !illegal_o);

    p_clear_r5: assert property (@(posedge clk) disable iff (rst)
        (instr_valid && opcode == 8'h00) |=> (acc_o == 4'h0) && !skip_o);

    p_cset_r6: assert property (@(posedge clk) disable iff (rst)
        (instr_valid && opcode == 8'h22) |=> carry_o && $stable(acc_o));

    p_nop_r7: assert property (@(posedge clk) disable iff (rst)
        (instr_valid && opcode == 8'h44)
        |=> $stable(acc_o) && $stable(carry_o) && !skip_o && !illegal_o);

    p_bad_imm_r8: assert property (@(posedge clk) disable iff (rst)
        (instr_valid && opcode == 8'h50)
        |=> illegal_o && !skip_o && $stable(acc_o) && $stable(carry_o));

    p_idle_r9: assert property (@(posedge clk) disable iff (rst)
        !instr_valid |=> $stable(acc_o) && $stable(carry_o) && !skip_o && !illegal_o);

    p_excl_r9: assert property (@(posedge clk) disable iff (rst)
        !(skip_o && illegal_o));
endmodule

bind nib_exec nib_exec_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .instr_valid (instr_valid),
    .opcode      (opcode),
    .acc_o       (acc_o),
    .carry_o     (carry_o),
    .skip_o      (skip_o),
    .illegal_o   (illegal_o)
);

// File: tb/nib_exec_bench.sv
`timescale 1ns/1ps
module nib_exec_bench;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       instr_valid = 1'b0;
    logic [7:0] opcode = 8'h00;
    logic [3:0] ram_nib = 4'h0;
    logic [3:0] acc_o;
    logic       carry_o, skip_o, illegal_o;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    logic [3:0] m_acc = 4'h0;
    logic       m_c   = 1'b0;

    always #5 clk = ~clk;

    nib_exec u_nib_exec (
        .clk(clk), .rst(rst), .instr_valid(instr_valid), .opcode(opcode),
        .ram_nib(ram_nib), .acc_o(acc_o), .carry_o(carry_o),
        .skip_o(skip_o), .illegal_o(illegal_o)
    );

    task automatic chk(string tag, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    task automatic check_all(string tag, logic es, logic ei);
        chk(tag, "acc", acc_o, m_acc);
        chk(tag, "carry", carry_o, m_c);
        chk(tag, "skip", skip_o, es);
        chk(tag, "illegal", illegal_o, ei);
    endtask

    // Expected result from the requirement text, then one strobe and a check
    task automatic run_op(string tag, logic [7:0] op, logic [3:0] m);
        logic [4:0] s;
        logic es = 1'b0, ei = 1'b0;
        if (op == 8'h30) begin
            s = {1'b0, m_acc} + {1'b0, m} + {4'b0, m_c};
            m_acc = s[3:0]; m_c = s[4]; es = s[4];
        end else if (op == 8'h31) begin
            m_acc = m_acc + m;
        end else if (op[7:4] == 4'h5 && op[3:0] != 0) begin
            s = {1'b0, m_acc} + {1'b0, op[3:0]};
            m_acc = s[3:0]; es = s[4];
        end else if (op == 8'h00) m_acc = 4'h0;
        else if (op == 8'h40) m_acc = ~m_acc;
        else if (op == 8'h32) m_c = 1'b0;
        else if (op == 8'h22) m_c = 1'b1;
        else if (op == 8'h02) m_acc = m_acc ^ m;
        else if (op == 8'h44) ;
        else ei = 1'b1;
        @(negedge clk);
        instr_valid = 1'b1; opcode = op; ram_nib = m;
        @(negedge clk);
        instr_valid = 1'b0; opcode = 8'hFF; ram_nib = ~m;
        check_all(tag, es, ei);
    endtask

    task automatic set_acc(logic [3:0] v);
        run_op("setup", 8'h00, 4'h0);
        if (v != 0) run_op("setup", {4'h5, v}, 4'h0);
    endtask

    task automatic t_reset_r1;
        set_acc(4'hB);
        run_op("setup", 8'h22, 4'h0);
        @(negedge clk); rst = 1'b1; instr_valid = 1'b1; opcode = 8'h30; ram_nib = 4'hF;
        @(negedge clk); rst = 1'b0; instr_valid = 1'b0;
        m_acc = 0; m_c = 0;
        check_all("R1", 1'b0, 1'b0);
    endtask

    task automatic t_addc_r2;
        for (int ci = 0; ci < 2; ci++) begin
            set_acc(4'h7);
            run_op("setup", ci ? 8'h22 : 8'h32, 4'h0);
            run_op("R2", 8'h30, 4'h8);   // 15 or 16
            set_acc(4'h9);
            run_op("setup", ci ? 8'h22 : 8'h32, 4'h0);
            run_op("R2", 8'h30, 4'h7);   // 16 or 17
        end
        set_acc(4'hF);
        run_op("setup", 8'h22, 4'h0);
        run_op("R2", 8'h30, 4'hF);       // 31
    endtask

    task automatic t_add_r3;
        run_op("setup", 8'h22, 4'h0);
        set_acc(4'hC);
        run_op("R3", 8'h31, 4'h9);       // overflow, no skip
        run_op("setup", 8'h32, 4'h0);
        run_op("R3", 8'h31, 4'h2);
    endtask

    task automatic t_imm_r4;
        run_op("setup", 8'h22, 4'h0);
        set_acc(4'h0);
        run_op("R4", 8'h51, 4'h0);
        run_op("R4", 8'h5E, 4'h0);       // 15, no skip
        run_op("R4", 8'h51, 4'h0);       // 16, skip, carry stays 1
        run_op("setup", 8'h32, 4'h0);
        run_op("R4", 8'h5F, 4'h0);       // 15
        run_op("R4", 8'h5F, 4'h0);       // 30, skip, carry stays 0
    endtask

    task automatic t_clr_inv_r5;
        set_acc(4'h6);
        run_op("R5", 8'h40, 4'h3);
        run_op("R5", 8'h40, 4'h3);
        run_op("R5", 8'h00, 4'h3);
        run_op("R5", 8'h40, 4'h0);
    endtask

    task automatic t_carry_r6;
        set_acc(4'hA);
        run_op("R6", 8'h22, 4'h5);
        run_op("R6", 8'h22, 4'h5);
        run_op("R6", 8'h32, 4'h5);
    endtask

    task automatic t_xor_nop_r7;
        set_acc(4'h5);
        run_op("R7", 8'h02, 4'hF);
        run_op("R7", 8'h02, 4'h3);
        run_op("setup", 8'h22, 4'h0);
        run_op("R7", 8'h44, 4'hF);
    endtask

    task automatic t_illegal_r8;
        logic [7:0] bad [6] = '{8'h50, 8'h01, 8'h33, 8'h45, 8'hFF, 8'h60};
        set_acc(4'h9);
        run_op("setup", 8'h22, 4'h0);
        foreach (bad[i]) run_op("R8", bad[i], 4'h7);
    endtask

    task automatic t_pulse_r9;
        set_acc(4'hF);
        run_op("R9", 8'h51, 4'h0);       // skip pulse
        @(negedge clk);
        check_all("R9", 1'b0, 1'b0);
        run_op("R9", 8'h50, 4'h0);       // illegal pulse
        @(negedge clk);
        check_all("R9", 1'b0, 1'b0);
    endtask

    initial begin
        repeat (2) @(negedge clk);
        check_all("R1", 1'b0, 1'b0);
        rst = 1'b0;
        t_addc_r2();
        t_add_r3();
        t_imm_r4();
        t_clr_inv_r5();
        t_carry_r6();
        t_xor_nop_r7();
        t_illegal_r8();
        t_pulse_r9();
        t_reset_r1();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog actual=1 expected=0");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule